// File: doc/BRIEF.md
# Step Attenuator Control Register

This block is the digital control front end of a six-bit step attenuator. It turns pin-level control into a registered six-bit attenuation code. A mode pin picks the control source. In serial mode, a shift register takes one bit per rising edge of a serial clock, most significant bit first. In parallel mode, six parallel pins supply the code. A latch enable sits between the selected source and the output. While latch enable is high, changes pass through to the output. When it falls, the output holds its value. Shifting goes on whatever the state of latch enable, so a new word can be loaded with latch enable low and applied with one high-then-low pulse.

The system clock is much faster than the pins. All pins are passed through synchronisers, and serial clock and latch enable edges are found from the synchronised copies. A synchronous reset pulse stands for power-on. On that cycle the starting code is loaded into both the output latch and the shift register. The starting code comes from the parallel pins, unless parallel mode is selected with latch enable low. In that case two preset-select pins choose one of four fixed codes.

Top module: `atten_ctrl`

## Requirements
- R1: With `serSel` high, the output latch takes its value from the shift register. With `serSel` low, it takes the value on `parCode`.
- R2: Each rising edge of `serClk` shifts the register one place toward the most significant bit and puts `serData` into bit 0. The first of six bits shifted ends up in bit 5. Code bit 0 is worth 0.5 dB, and each higher bit doubles, up to 16 dB for bit 5.
- R3: Shifting happens with `latchEn` low as well, and while `latchEn` stays low it does not change `attenCode`.
- R4: While `latchEn` is high, `attenCode` follows the selected source within six system clock cycles of a pin change. After `latchEn` falls, `attenCode` holds until `latchEn` is high again.
- R5: In parallel mode with `latchEn` high, `attenCode` follows `parCode`.
- R6: In parallel mode with `latchEn` low, changes on `parCode` leave `attenCode` unchanged. A high-then-low pulse on `latchEn` captures the `parCode` value present during the pulse.
- R7: Reset with `serSel` low and `latchEn` low loads a code chosen by `presetSel`: 00 gives 000000 (0 dB), 01 gives 010000 (8 dB), 10 gives 100000 (16 dB), 11 gives 111110 (31 dB).
- R8: Reset with `serSel` high, or with `latchEn` high, loads `parCode` and ignores `presetSel`. The same starting code is also loaded into the shift register, so later shifts continue from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| serSel | input | 1 | Mode select: 1 serial, 0 parallel |
| serData | input | 1 | Serial data bit |
| serClk | input | 1 | Serial shift clock; sampled on its rising edge |
| latchEn | input | 1 | Latch enable: high transparent, low hold |
| parCode | input | 6 | Parallel attenuation code; also the starting code |
| presetSel | input | 2 | Preset choice used at reset in parallel mode with latch enable low |
| attenCode | output | 6 | Attenuation code, bit 0 = 0.5 dB up to bit 5 = 16 dB |

## Verification
A shift register holding the wrong contents stays hidden while latch enable is low. It shows at the output only after the next latch pulse, or as soon as latch enable is raised. For that reason, every serial load is checked both before and after the pulse. A wrong hold or source choice in the output latch shows within the six-cycle window after the pin change that should or should not have moved the output. A wrong starting code shows on the first sample after reset, and it shows again later through the bits it leaves behind in the shift register.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;

  localparam int ATTEN_W = 6;

  typedef logic [ATTEN_W-1:0] attenCode_t;

  typedef struct packed {
    logic shiftEn;
    logic latchLoad;
    logic selSerial;
  } attenStrobe_t;

  localparam attenCode_t PRESET_ZERO = '0;
  localparam attenCode_t PRESET_MID  = attenCode_t'(1) << (ATTEN_W - 2);
  localparam attenCode_t PRESET_HIGH = attenCode_t'(1) << (ATTEN_W - 1);
  localparam attenCode_t PRESET_MAX  = {{(ATTEN_W-1){1'b1}}, 1'b0};

  function automatic attenCode_t presetCode(input logic [1:0] sel);
    case (sel)
      2'b01:   presetCode = PRESET_MID;
      2'b10:   presetCode = PRESET_HIGH;
      2'b11:   presetCode = PRESET_MAX;
      default: presetCode = PRESET_ZERO;
    endcase
  endfunction

  function automatic attenCode_t startCode(input logic serialMode,
                                           input logic leLevel,
                                           input logic [1:0] sel,
                                           input attenCode_t par);
    if (!serialMode && !leLevel) startCode = presetCode(sel);
    else                         startCode = par;
  endfunction

endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= din;
    end else begin
      stageQ[0] <= din;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/atten_ctrl_seq.sv
module atten_ctrl_seq
  import atten_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         serClkRaw,
  input  logic         syncSerSel,
  input  logic         syncSerClk,
  input  logic         syncLatchEn,
  output attenStrobe_t ctl
);

  logic serClkPrev;

  always_ff @(posedge clk) begin
    if (rst) serClkPrev <= serClkRaw;
    else     serClkPrev <= syncSerClk;
  end

  always_comb begin
    ctl.shiftEn   = syncSerClk & ~serClkPrev;
    ctl.latchLoad = syncLatchEn;
    ctl.selSerial = syncSerSel;
  end

  // R2: one shift per rising edge of the serial clock, never two in a row
  assert_one_shift_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftEn |=> !ctl.shiftEn);

endmodule

// File: rtl/atten_ctrl_dp.sv
module atten_ctrl_dp
  import atten_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  attenStrobe_t ctl,
  input  logic         serBit,
  input  attenCode_t   parIn,
  input  attenCode_t   initCode,
  output attenCode_t   attenCode
);

  attenCode_t shiftQ;
  attenCode_t latchQ;
  attenCode_t latchSrc;

  assign latchSrc = ctl.selSerial ? shiftQ : parIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftQ <= initCode;
      latchQ <= initCode;
    end else begin
      if (ctl.shiftEn) shiftQ <= {shiftQ[ATTEN_W-2:0], serBit};
      if (ctl.latchLoad) latchQ <= latchSrc;
    end
  end

  assign attenCode = latchQ;

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.shiftEn |=> (shiftQ == {$past(shiftQ[ATTEN_W-2:0]), $past(serBit)}));

  assert_shift_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !ctl.shiftEn |=> $stable(shiftQ));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !ctl.latchLoad |=> $stable(attenCode));

  assert_parallel_follow_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl.latchLoad && !ctl.selSerial) |=> (attenCode == $past(parIn)));

  assert_serial_source_R1: assert property (@(posedge clk) disable iff (rst)
    (ctl.latchLoad && ctl.selSerial) |=> (attenCode == $past(shiftQ)));

endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
  import atten_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               serSel,
  input  logic               serData,
  input  logic               serClk,
  input  logic               latchEn,
  input  logic [ATTEN_W-1:0] parCode,
  input  logic [1:0]         presetSel,
  output logic [ATTEN_W-1:0] attenCode
);

  localparam int BUS_W = ATTEN_W + 4;

  logic [BUS_W-1:0] rawBus;
  logic [BUS_W-1:0] syncBus;
  attenStrobe_t     ctl;
  attenCode_t       initCode;

  assign rawBus   = {serSel, serData, serClk, latchEn, parCode};
  assign initCode = startCode(serSel, latchEn, presetSel, parCode);

  atten_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rawBus),
    .dout (syncBus)
  );

  atten_ctrl_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .serClkRaw   (serClk),
    .syncSerSel  (syncBus[ATTEN_W+3]),
    .syncSerClk  (syncBus[ATTEN_W+1]),
    .syncLatchEn (syncBus[ATTEN_W]),
    .ctl         (ctl)
  );

  atten_ctrl_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .serBit    (syncBus[ATTEN_W+2]),
    .parIn     (syncBus[ATTEN_W-1:0]),
    .initCode  (initCode),
    .attenCode (attenCode)
  );

endmodule

// File: tb/atten_ctrl_tb.sv
module atten_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic       serSel = 1'b0;
  logic       serData = 1'b0;
  logic       serClk = 1'b0;
  logic       latchEn = 1'b0;
  logic [5:0] parCode = '0;
  logic [1:0] presetSel = '0;
  logic [5:0] attenCode;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #5 clk = ~clk;

  atten_ctrl u_dut (
    .clk       (clk),
    .rst       (rst),
    .serSel    (serSel),
    .serData   (serData),
    .serClk    (serClk),
    .latchEn   (latchEn),
    .parCode   (parCode),
    .presetSel (presetSel),
    .attenCode (attenCode)
  );

  // fields: serSel, latchEn, presetSel[1:0], parCode[5:0], expected[5:0]
  localparam logic [15:0] RESET_VEC [8] = '{
    {1'b0, 1'b0, 2'b00, 6'b101010, 6'b000000},
    {1'b0, 1'b0, 2'b01, 6'b101010, 6'b010000},
    {1'b0, 1'b0, 2'b10, 6'b000111, 6'b100000},
    {1'b0, 1'b0, 2'b11, 6'b000001, 6'b111110},
    {1'b1, 1'b0, 2'b11, 6'b010101, 6'b010101},
    {1'b1, 1'b1, 2'b01, 6'b110011, 6'b110011},
    {1'b0, 1'b1, 2'b10, 6'b001100, 6'b001100},
    {1'b1, 1'b0, 2'b00, 6'b111111, 6'b111111}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: attenCode=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    tick(6);
  endtask

  task automatic shiftBit(input logic b);
    serData = b;
    tick(4);
    serClk = 1'b1;
    tick(4);
    serClk = 1'b0;
    tick(4);
  endtask

  task automatic shiftWord(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic pulseLe();
    latchEn = 1'b1;
    tick(6);
    latchEn = 1'b0;
    tick(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    tick(2);
    // R7 / R8: start-up code table
    for (int i = 0; i < 8; i++) begin
      serSel    = RESET_VEC[i][15];
      latchEn   = RESET_VEC[i][14];
      presetSel = RESET_VEC[i][13:12];
      parCode   = RESET_VEC[i][11:6];
      doReset();
      check(i < 4 ? "R7 preset start code" : "R8 pin start code",
            attenCode, RESET_VEC[i][5:0]);
    end

    // R8: shift register starts from the loaded code
    serSel = 1'b1; latchEn = 1'b0; presetSel = 2'b11; parCode = 6'b100110;
    doReset();
    check("R8 serial start", attenCode, 6'b100110);
    parCode = 6'b000000;
    shiftBit(1'b1);
    check("R3 shift with LE low keeps output", attenCode, 6'b100110);
    pulseLe();
    check("R8 shift continues from start code", attenCode, 6'b001101);

    // R2: full word, MSB first
    shiftWord(6'b110001);
    check("R3 word loaded under LE low", attenCode, 6'b001101);
    pulseLe();
    check("R2 word order MSB first", attenCode, 6'b110001);
    shiftWord(6'b100000);
    pulseLe();
    check("R2 16 dB bit lands in bit 5", attenCode, 6'b100000);
    shiftWord(6'b110001);
    pulseLe();

    // R4: transparent then hold
    latchEn = 1'b1;
    tick(6);
    check("R4 transparent", attenCode, 6'b110001);
    shiftBit(1'b0);
    check("R4 follows shift while LE high", attenCode, 6'b100010);
    latchEn = 1'b0;
    tick(6);
    shiftBit(1'b1);
    check("R4 hold after LE falls", attenCode, 6'b100010);

    // R1 / R6: parallel mode with LE low
    serSel = 1'b0; parCode = 6'b011011;
    tick(6);
    check("R6 parallel change ignored", attenCode, 6'b100010);
    pulseLe();
    check("R6 LE pulse captures parallel", attenCode, 6'b011011);
    parCode = 6'b000011;
    tick(8);
    check("R6 later change ignored", attenCode, 6'b011011);

    // R5: parallel direct
    latchEn = 1'b1;
    tick(6);
    check("R5 direct follow", attenCode, 6'b000011);
    parCode = 6'b111000;
    tick(6);
    check("R5 direct follow second value", attenCode, 6'b111000);
    latchEn = 1'b0;
    tick(6);
    parCode = 6'b000000;
    tick(6);
    check("R4 parallel hold", attenCode, 6'b111000);

    // R1: back to serial source with LE high
    serSel = 1'b1;
    latchEn = 1'b1;
    tick(6);
    check("R1 serial source selected", attenCode, 6'b000101);
    latchEn = 1'b0;
    tick(4);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule